// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Scheduler

This block decides when a DDR SDRAM controller must spend a slot on an AUTO REFRESH command. An external timebase pulses once per average refresh interval; every pulse adds one owed refresh to a backlog. Refreshes are issued opportunistically while the bank tracker reports the device quiet. While the controller stays busy they are postponed, up to a programmable urgency level. At that level ordinary commands are held off, open rows are closed with a precharge-all, and the refresh is forced. The backlog saturates at a ceiling that corresponds to the longest legal gap between two refreshes.

The block can also park the device in self refresh. On request it waits until no access is in flight and no row is open, then pulls the clock enable low. When the request is withdrawn it raises clock enable again. It then keeps ordinary commands blocked for a short exit delay and read commands blocked for a much longer one. Owed refreshes are dropped while the device refreshes itself. The ready outputs tell the controller, cycle by cycle, whether it may issue an ordinary command or a read.

Top module: `refresh_sched`

## Requirements
- R1: After reset cke is 1, ref_cmd, pre_all, req_normal and req_urgent are 0, and cmd_ready and read_ready are 1 while all inputs are 0.
- R2: The backlog rises by one at each clock edge with refi_tick high and falls by one at each edge where a refresh is taken; both at once leave it unchanged; at CEIL_LVL a further tick is dropped, so the count never wraps.
- R3: req_normal is 1 when the backlog is between 1 and URGENT_LVL-1; req_urgent is 1 when the backlog is URGENT_LVL or more; the two are never 1 together.
- R4: With a non-zero backlog, busy low and bank_open low in the run state, ref_cmd is 1 for exactly the one cycle after that edge.
- R5: With the backlog at the urgency level, cmd_ready is 0. Once busy is low, if bank_open is 1 then pre_all is 1 for one cycle, followed by RP_CYC idle cycles, and then ref_cmd.
- R6: cmd_ready is 0 for RFC_CYC cycles starting with the ref_cmd cycle.
- R7: Self refresh is entered (cke 0 from the next cycle) only from the run state with sr_req 1, busy 0, bank_open 0 and no backlog; a pending refresh is issued first.
- R8: While cke is 0 the backlog is held at zero and refi_tick has no effect; req_normal and req_urgent read 0 in the first cycle after exit.
- R9: cke returns to 1 in the cycle after sr_req is seen low; cmd_ready first returns XSNR_CYC cycles and read_ready XSRD_CYC cycles after the cke rise.
- R10: Under any busy pattern in which accesses end once cmd_ready is 0, the gap between two ref_cmd pulses never exceeds CEIL_LVL refresh intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refi_tick | input | 1 | One-cycle pulse per average refresh interval |
| busy | input | 1 | A read or write access is in flight |
| bank_open | input | 1 | At least one bank holds an open row |
| sr_req | input | 1 | Level request to stay in self refresh |
| req_normal | output | 1 | Refresh owed, not yet urgent |
| req_urgent | output | 1 | Backlog at urgency level, refresh forced |
| pre_all | output | 1 | Issue a precharge-all this cycle |
| ref_cmd | output | 1 | Issue an AUTO REFRESH this cycle |
| cke | output | 1 | Clock enable to the device |
| cmd_ready | output | 1 | Ordinary command may issue this cycle |
| read_ready | output | 1 | Read command may issue this cycle |

## Verification
The command outputs and cke are state decodes that change one cycle after the deciding edge, while cmd_ready and read_ready also follow the current busy, bank_open and sr_req inputs in the same cycle. The bench therefore advances its behavioural model at each rising edge, drives new inputs 1 ns later, and compares every output 2 ns after the edge, with the combinational part of the model evaluated on the freshly driven inputs. Exit delays are measured from the first cycle in which cke reads 1: cmd_ready is expected at exactly XSNR_CYC cycles and read_ready at exactly XSRD_CYC, with the timebase paused so that no refresh competes for that slot.

// File: rtl/rs_pkg.sv
package rs_pkg;
   typedef enum logic [2:0] {
      PH_RUN   = 3'd0,
      PH_PRE   = 3'd1,
      PH_PWAIT = 3'd2,
      PH_REF   = 3'd3,
      PH_RFC   = 3'd4,
      PH_SR    = 3'd5,
      PH_XS    = 3'd6
   } rs_phase_e;
endpackage

// File: rtl/rs_backlog.sv
module rs_backlog #(
   parameter int CEIL_LVL = 9,
   parameter int BW       = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          dec,
   input  logic          clr,
   output logic [BW-1:0] cnt
);
   localparam logic [BW-1:0] TOP = BW'(CEIL_LVL);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt <= '0;
      end else if (tick && !dec) begin
         if (cnt != TOP) cnt <= cnt + 1'b1;
      end else if (dec && !tick) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/rs_delay.sv
module rs_delay #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         idle
);
   logic [W-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n)              left <= '0;
      else if (load)           left <= val;
      else if (left != '0)     left <= left - 1'b1;
   end

   assign idle = (left == '0);
endmodule

// File: rtl/rs_fsm.sv
module rs_fsm import rs_pkg::*; #(
   parameter int CW       = 8,
   parameter int RFC_CYC  = 8,
   parameter int RP_CYC   = 2,
   parameter int XSNR_CYC = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pend,
   input  logic          urgent,
   input  logic          busy,
   input  logic          bank_open,
   input  logic          sr_req,
   input  logic          ph_idle,
   output rs_phase_e     phase,
   output rs_phase_e     phase_n,
   output logic          ph_load,
   output logic [CW-1:0] ph_val,
   output logic          rd_load,
   output logic          take_ref
);
   localparam logic [CW-1:0] RP_LOAD  = CW'(RP_CYC - 1);
   localparam logic [CW-1:0] RFC_LOAD = CW'(RFC_CYC - 2);
   localparam logic [CW-1:0] XS_LOAD  = CW'(XSNR_CYC - 1);

   always_comb begin
      phase_n  = phase;
      ph_load  = 1'b0;
      ph_val   = '0;
      rd_load  = 1'b0;
      take_ref = 1'b0;
      unique case (phase)
         PH_RUN: begin
            if (!busy && urgent && bank_open) begin
               phase_n = PH_PRE;
            end else if (!busy && pend && !bank_open) begin
               phase_n  = PH_REF;
               take_ref = 1'b1;
            end else if (!busy && sr_req && !bank_open) begin
               phase_n = PH_SR;
            end
         end
         PH_PRE: begin
            phase_n = PH_PWAIT;
            ph_load = 1'b1;
            ph_val  = RP_LOAD;
         end
         PH_PWAIT: begin
            if (ph_idle) begin
               phase_n  = PH_REF;
               take_ref = 1'b1;
            end
         end
         PH_REF: begin
            phase_n = PH_RFC;
            ph_load = 1'b1;
            ph_val  = RFC_LOAD;
         end
         PH_RFC: begin
            if (ph_idle) phase_n = PH_RUN;
         end
         PH_SR: begin
            if (!sr_req) begin
               phase_n = PH_XS;
               ph_load = 1'b1;
               ph_val  = XS_LOAD;
               rd_load = 1'b1;
            end
         end
         PH_XS: begin
            if (ph_idle) phase_n = PH_RUN;
         end
         default: phase_n = PH_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= PH_RUN;
      else        phase <= phase_n;
   end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched import rs_pkg::*; #(
   parameter int CEIL_LVL   = 9,
   parameter int URGENT_LVL = 7,
   parameter int RFC_CYC    = 8,
   parameter int RP_CYC     = 2,
   parameter int XSNR_CYC   = 8,
   parameter int XSRD_CYC   = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic refi_tick,
   input  logic busy,
   input  logic bank_open,
   input  logic sr_req,
   output logic req_normal,
   output logic req_urgent,
   output logic pre_all,
   output logic ref_cmd,
   output logic cke,
   output logic cmd_ready,
   output logic read_ready
);
   localparam int BW      = $clog2(CEIL_LVL + 1);
   localparam int LONG_A  = (RFC_CYC > RP_CYC) ? RFC_CYC : RP_CYC;
   localparam int LONG_B  = (XSNR_CYC > XSRD_CYC) ? XSNR_CYC : XSRD_CYC;
   localparam int LONGEST = (LONG_A > LONG_B) ? LONG_A : LONG_B;
   localparam int CW      = $clog2(LONGEST + 1);

   generate
      if (URGENT_LVL < 2 || URGENT_LVL >= CEIL_LVL) begin : g_bad_urgent
         $error("URGENT_LVL must lie in 2 .. CEIL_LVL-1");
      end
      if (RFC_CYC < 2 || RP_CYC < 1) begin : g_bad_cmd_time
         $error("RFC_CYC needs at least 2 and RP_CYC at least 1");
      end
      if (XSNR_CYC < 1 || XSRD_CYC < XSNR_CYC) begin : g_bad_exit
         $error("exit delays must satisfy 1 <= XSNR_CYC <= XSRD_CYC");
      end
   endgenerate

   logic [BW-1:0] backlog;
   rs_phase_e     phase, phase_n;
   logic          ph_load, ph_idle, rd_load, rd_idle, take_ref;
   logic [CW-1:0] ph_val;
   logic          pend, urgent, clr_bl;

   assign pend   = (backlog != '0);
   assign urgent = (backlog >= BW'(URGENT_LVL));
   assign clr_bl = (phase == PH_SR) || (phase_n == PH_SR);

   rs_backlog #(.CEIL_LVL(CEIL_LVL), .BW(BW)) u_backlog (
      .clk(clk), .rst_n(rst_n), .tick(refi_tick), .dec(take_ref),
      .clr(clr_bl), .cnt(backlog)
   );

   rs_fsm #(.CW(CW), .RFC_CYC(RFC_CYC), .RP_CYC(RP_CYC), .XSNR_CYC(XSNR_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .pend(pend), .urgent(urgent), .busy(busy),
      .bank_open(bank_open), .sr_req(sr_req), .ph_idle(ph_idle),
      .phase(phase), .phase_n(phase_n), .ph_load(ph_load), .ph_val(ph_val),
      .rd_load(rd_load), .take_ref(take_ref)
   );

   rs_delay #(.W(CW)) u_phase_wait (
      .clk(clk), .rst_n(rst_n), .load(ph_load), .val(ph_val), .idle(ph_idle)
   );

   rs_delay #(.W(CW)) u_read_wait (
      .clk(clk), .rst_n(rst_n), .load(rd_load), .val(CW'(XSRD_CYC)), .idle(rd_idle)
   );

   assign req_urgent = urgent;
   assign req_normal = pend && !urgent;
   assign pre_all    = (phase == PH_PRE);
   assign ref_cmd    = (phase == PH_REF);
   assign cke        = (phase != PH_SR);
   assign cmd_ready  = (phase == PH_RUN) && !urgent && (phase_n == PH_RUN);
   assign read_ready = cmd_ready && rd_idle;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
   parameter int CEIL_LVL = 9,
   parameter int BW       = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          bank_open,
   input logic          sr_req,
   input logic          req_normal,
   input logic          req_urgent,
   input logic          pre_all,
   input logic          ref_cmd,
   input logic          cke,
   input logic          cmd_ready,
   input logic          read_ready,
   input logic [BW-1:0] backlog
);
   assert_ceiling_R10: assert property (@(posedge clk) disable iff (!rst_n)
      backlog <= BW'(CEIL_LVL));

   assert_req_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_normal && req_urgent));

   assert_ref_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cmd |=> !ref_cmd);

   assert_pre_urgent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pre_all |-> $past(req_urgent));

   assert_pre_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pre_all |=> !ref_cmd);

   assert_ref_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cmd |-> !cmd_ready);

   assert_sr_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke) |-> $past(sr_req && !busy && !bank_open));

   assert_sr_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> (!req_normal && !req_urgent && !cmd_ready));

   assert_exit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> (!cmd_ready && !read_ready));
endmodule

bind refresh_sched refresh_sched_chk #(.CEIL_LVL(CEIL_LVL), .BW(BW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .bank_open(bank_open), .sr_req(sr_req),
   .req_normal(req_normal), .req_urgent(req_urgent), .pre_all(pre_all),
   .ref_cmd(ref_cmd), .cke(cke), .cmd_ready(cmd_ready), .read_ready(read_ready),
   .backlog(backlog)
);

// File: tb/test_refresh_sched.sv
module test_refresh_sched;
   localparam int TICK_PER = 40;
   localparam int CEIL     = 9;
   localparam int URG      = 7;
   localparam int RFC      = 8;
   localparam int RP       = 2;
   localparam int XSNR     = 8;
   localparam int XSRD     = 200;

   localparam int M_RUN = 0, M_PRE = 1, M_PWAIT = 2, M_REF = 3, M_RFC = 4, M_SR = 5, M_XS = 6;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, refi_tick, busy, bank_open, sr_req;
   logic req_normal, req_urgent, pre_all, ref_cmd, cke, cmd_ready, read_ready;

   refresh_sched #(.CEIL_LVL(CEIL), .URGENT_LVL(URG), .RFC_CYC(RFC), .RP_CYC(RP),
                   .XSNR_CYC(XSNR), .XSRD_CYC(XSRD)) i_refresh_sched (
      .clk(clk), .rst_n(rst_n), .refi_tick(refi_tick), .busy(busy),
      .bank_open(bank_open), .sr_req(sr_req), .req_normal(req_normal),
      .req_urgent(req_urgent), .pre_all(pre_all), .ref_cmd(ref_cmd), .cke(cke),
      .cmd_ready(cmd_ready), .read_ready(read_ready)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // behavioural reference state
   int m_ph, m_bl, m_rem, m_rd;
   bit m_rdy = 1;
   int tcnt = 0;
   bit tick_en = 1;
   bit prev_cke = 1, w_c = 0, w_r = 0, gap_on = 0;
   int since = 0, gap = 0;

   task automatic chk(string rq, string nm, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0b expected=%0b t=%0t", rq, nm, act, exp, $time);
      end
   endtask

   task automatic chk_int(string rq, string nm, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d t=%0t", rq, nm, act, exp, $time);
      end
   endtask

   task automatic model_step(bit tk, bit bz, bit op, bit sr);
      bit was_sr = (m_ph == M_SR);
      bit owed   = (m_bl > 0);
      bit hot    = (m_bl >= URG);
      bit dec    = 0;
      bit to_sr  = 0;
      if (m_rd > 0) m_rd--;
      case (m_ph)
         M_RUN: begin
            if (!bz && hot && op) m_ph = M_PRE;
            else if (!bz && owed && !op) begin m_ph = M_REF; dec = 1; end
            else if (!bz && sr && !op) begin m_ph = M_SR; to_sr = 1; end
         end
         M_PRE:   begin m_ph = M_PWAIT; m_rem = RP; end
         M_PWAIT: begin m_rem--; if (m_rem == 0) begin m_ph = M_REF; dec = 1; end end
         M_REF:   begin m_ph = M_RFC; m_rem = RFC - 1; end
         M_RFC:   begin m_rem--; if (m_rem == 0) m_ph = M_RUN; end
         M_SR:    if (!sr) begin m_ph = M_XS; m_rem = XSNR; m_rd = XSRD; end
         M_XS:    begin m_rem--; if (m_rem == 0) m_ph = M_RUN; end
         default: m_ph = M_RUN;
      endcase
      if (was_sr || to_sr) m_bl = 0;
      else if (tk && !dec) begin if (m_bl < CEIL) m_bl++; end
      else if (dec && !tk) m_bl--;
   endtask

   task automatic compare_all();
      bit hot  = (m_bl >= URG);
      bit take = (m_ph == M_RUN) && !busy &&
                 ((hot && bank_open) || (!bank_open && (m_bl > 0 || sr_req)));
      bit rdy  = (m_ph == M_RUN) && !hot && !take;
      chk("R4", "ref_cmd",    ref_cmd,    m_ph == M_REF);
      chk("R5", "pre_all",    pre_all,    m_ph == M_PRE);
      chk("R7", "cke",        cke,        m_ph != M_SR);
      chk("R3", "req_urgent", req_urgent, hot);
      chk("R3", "req_normal", req_normal, (m_bl > 0) && !hot);
      chk("R6", "cmd_ready",  cmd_ready,  rdy);
      chk("R9", "read_ready", read_ready, rdy && (m_rd == 0));
      m_rdy = rdy;
   endtask

   task automatic cyc(int mode);
      @(posedge clk);
      #1;
      model_step(refi_tick, busy, bank_open, sr_req);
      tcnt = (tcnt == TICK_PER - 1) ? 0 : tcnt + 1;
      refi_tick = tick_en && (tcnt == TICK_PER - 1);
      case (mode)
         1: begin
            if (m_rdy) busy = ($urandom % 10) < 7;
            else if (busy) busy = ($urandom % 3) != 0;
            if (m_ph == M_PRE) bank_open = 0;
            else if (m_rdy && ($urandom % 8) == 0) bank_open = ~bank_open;
            sr_req = 0;
         end
         2: begin busy = 0; bank_open = 0; sr_req = 1; end
         3: begin busy = 1; bank_open = 1; sr_req = 0; end
         default: begin busy = 0; bank_open = 0; sr_req = 0; end
      endcase
      #1;
      compare_all();
      // self-refresh exit timing, measured at the ports
      if (cke && !prev_cke) begin
         since = 0; w_c = 1; w_r = 1;
         chk("R8", "backlog empty after exit", req_normal | req_urgent, 1'b0);
      end else begin
         since++;
      end
      if (w_c && (cmd_ready || since == XSNR)) begin
         chk_int("R9", "cmd_ready delay", cmd_ready ? since : -1, XSNR);
         w_c = 0;
      end
      if (w_r && (read_ready || since == XSRD)) begin
         chk_int("R9", "read_ready delay", read_ready ? since : -1, XSRD);
         w_r = 0;
      end
      prev_cke = cke;
      // refresh gap ceiling under random traffic
      if (!cke) gap_on = 0;
      if (ref_cmd) begin
         if (gap_on && mode == 1)
            chk("R10", "refresh gap within ceiling", gap <= CEIL * TICK_PER, 1'b1);
         gap = 0; gap_on = (mode == 1);
      end else begin
         gap++;
      end
   endtask

   task automatic run(int mode, int n);
      gap_on = 0;
      for (int i = 0; i < n; i++) cyc(mode);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 0; refi_tick = 0; busy = 0; bank_open = 0; sr_req = 0;
      m_ph = M_RUN; m_bl = 0; m_rem = 0; m_rd = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      #1;
      chk("R1", "reset cke",        cke,        1'b1);
      chk("R1", "reset ref_cmd",    ref_cmd,    1'b0);
      chk("R1", "reset pre_all",    pre_all,    1'b0);
      chk("R1", "reset requests",   req_normal | req_urgent, 1'b0);
      chk("R1", "reset cmd_ready",  cmd_ready,  1'b1);
      chk("R1", "reset read_ready", read_ready, 1'b1);

      run(0, 300);                       // R2 R4: idle, one refresh per tick
      run(1, 4000);                      // R10: random traffic
      run(3, (CEIL + 2) * TICK_PER);     // R2: saturation while held busy
      chk("R2", "saturated backlog still urgent", req_urgent, 1'b1);
      run(1, 1500);                      // R5: forced precharge then refresh
      run(2, 400);                       // R7 R8: self refresh across ticks
      tick_en = 0;
      run(0, XSRD + 30);                 // R9: exit delays
      tick_en = 1;
      run(1, 3000);
      run(2, 250);
      tick_en = 0;
      run(0, XSRD + 30);
      tick_en = 1;
      run(0, 200);

      done = 1;
      summary();
      $finish;
   end
endmodule